// File: doc/BRIEF.md
# Triggered Cascaded Clock Divider

This block produces two related divided clocks inside a single kernel clock domain. The first stage divides the kernel clock to make a processing tick. The second stage counts those ticks to make a bitstream clock. The bitstream clock can be routed to two pins, and each pin has its own drive enable and its own direction bit. Both stages are modelled as a one-cycle clock-enable pulse together with a level waveform. No real clock is generated.

Software configures the block through a single-word write port. The generator starts in one of two ways: in free mode it starts at once when the run bit is set, and in trigger mode it starts only after a chosen edge on one of four trigger inputs. While the generator is running, its ratios and start settings are frozen. The run bit and the pin bits stay writable, so the generator can always be stopped.

Top module: `trig_clk_div`

## Requirements
- R1: After reset, `active`, `proc_ce`, `proc_lvl`, `bit_ce`, `bit_lvl`, `pin_clk` and `pin_oe` are all 0.
- R2: In free mode (mode bit 0), a write that sets the run bit makes `active` 1 from the clock edge that takes the write.
- R3: In trigger mode (mode bit 1), `active` stays 0 after the run bit is set, until an edge of the selected input `trig_in[src]` occurs. A rising edge starts the generator when the sensitivity bit is 0, and a falling edge when it is 1. Edges on other inputs are ignored. A trigger input change applied before clock edge k shows as `active` = 1 after edge k+2.
- R4: With processing ratio field P, `proc_ce` pulses once every P+1 cycles while active. The last cycle of each period carries the pulse. `proc_lvl` is high in the last floor((P+1)/2) cycles of each period. For P = 0, `proc_lvl` stays high for as long as the generator is active.
- R5: With bit ratio field B, `bit_ce` pulses on every (B+1)-th `proc_ce`. `bit_lvl` is high for the last floor((B+1)/2) processing ticks of each bit period. For B = 0, `bit_lvl` follows `proc_lvl`.
- R6: `pin_clk[i]` equals `bit_lvl` when pin enable i is 1, and is 0 otherwise. `pin_oe[i]` equals direction bit i (1 = output, 0 = input).
- R7: While `active` is 1, writes leave the mode, sensitivity, source and both ratio fields unchanged. The run bit, the pin enables and the direction bits are still updated.
- R8: A write that clears the run bit makes `active` and every divided output 0 from that edge onward, and both counters restart from zero. After trigger mode is re-enabled, a new trigger edge is required; a trigger input that is already at the trigger level does not start the generator.
- R9: Write word layout:
  - bit 0: run
  - bits 2:1: pin enables (bit 1 = pin 0)
  - bit 3: mode
  - bits 5:4: directions (bit 4 = pin 0)
  - bit 6: sensitivity
  - bits 8:7: trigger source
  - bits 12:9: bit ratio B
  - bits 16:13: processing ratio P

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Kernel clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Configuration write strobe |
| wr_data | input | 17 | Configuration write word (layout in R9) |
| trig_in | input | 4 | Asynchronous trigger inputs |
| active | output | 1 | Generator running flag |
| proc_ce | output | 1 | Processing clock-enable pulse |
| proc_lvl | output | 1 | Processing clock level waveform |
| bit_ce | output | 1 | Bitstream clock-enable pulse |
| bit_lvl | output | 1 | Bitstream clock level waveform |
| pin_clk | output | 2 | Per-pin bitstream clock |
| pin_oe | output | 2 | Per-pin output direction |

## Verification
The assertions check several properties on every cycle:
- a stop write always drops `active` on the next cycle;
- neither clock-enable pulse appears while the generator is idle;
- a bit pulse always coincides with a processing pulse;
- the pins are quiet while idle;
- the processing ratio cannot change during a run;
- processing pulses are never back to back when the ratio is above one.

Only the bench scenarios can show the exact waveform shapes for odd and even ratios, the three-edge trigger latency, that edges of the opposite sense or on unselected inputs are rejected, and the need for a fresh edge after re-enabling. The bench shows these by comparing against a reference model on every cycle and by counting pulses over known windows.

// File: rtl/tcd_pkg.sv
package tcd_pkg;
    parameter int SEL_W  = 2;
    parameter int NTRIG  = 1 << SEL_W;
    parameter int NPIN   = 2;
    parameter int BDIV_W = 4;
    parameter int PDIV_W = 4;

    localparam int P_RUN  = 0;
    localparam int P_PEN  = P_RUN + 1;
    localparam int P_MODE = P_PEN + NPIN;
    localparam int P_DIR  = P_MODE + 1;
    localparam int P_FALL = P_DIR + NPIN;
    localparam int P_SEL  = P_FALL + 1;
    localparam int P_BDIV = P_SEL + SEL_W;
    localparam int P_PDIV = P_BDIV + BDIV_W;
    localparam int WR_W   = P_PDIV + PDIV_W;

    typedef struct packed {
        logic              run;
        logic [NPIN-1:0]   pin_en;
        logic [NPIN-1:0]   pin_dir;
        logic              trig_mode;
        logic              trig_fall;
        logic [SEL_W-1:0]  src;
        logic [BDIV_W-1:0] bdiv;
        logic [PDIV_W-1:0] pdiv;
    } cfg_t;

    // Applies one write; protected fields keep their value when locked.
    function automatic cfg_t apply_write(cfg_t cur, logic [WR_W-1:0] w, logic locked);
        cfg_t nxt;
        nxt         = cur;
        nxt.run     = w[P_RUN];
        nxt.pin_en  = w[P_PEN +: NPIN];
        nxt.pin_dir = w[P_DIR +: NPIN];
        if (!locked) begin
            nxt.trig_mode = w[P_MODE];
            nxt.trig_fall = w[P_FALL];
            nxt.src       = w[P_SEL +: SEL_W];
            nxt.bdiv      = w[P_BDIV +: BDIV_W];
            nxt.pdiv      = w[P_PDIV +: PDIV_W];
        end
        return nxt;
    endfunction
endpackage

// File: rtl/tcd_trig_edge.sv
module tcd_trig_edge #(
    parameter int NTRIG = 4,
    parameter int SEL_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NTRIG-1:0] trig_in,
    input  logic [SEL_W-1:0] src,
    input  logic             fall,
    output logic             hit
);
    typedef struct packed {
        logic s1;
        logic s2;
        logic s3;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d.s1 = trig_in[src];
        st_d.s2 = st_q.s1;
        st_d.s3 = st_q.s2;
        hit     = fall ? (st_q.s3 & ~st_q.s2) : (st_q.s2 & ~st_q.s3);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/tcd_div.sv
module tcd_div #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         run,
    input  logic         keep,
    input  logic         tick,
    input  logic         pass_lvl,
    input  logic [W-1:0] ratio_m1,
    output logic         ce,
    output logic         lvl
);
    logic [W-1:0] cnt_d, cnt_q;
    logic [W:0]   ratio;
    logic [W:0]   thr;
    logic         wrap;

    always_comb begin
        ratio = {1'b0, ratio_m1} + (W+1)'(1);
        thr   = ratio - (ratio >> 1);
        wrap  = (cnt_q == ratio_m1);
        ce    = run & tick & wrap;
        if (ratio_m1 == '0) lvl = run & pass_lvl;
        else                lvl = run & ({1'b0, cnt_q} >= thr);
        if (!(run & keep))  cnt_d = '0;
        else if (!tick)     cnt_d = cnt_q;
        else if (wrap)      cnt_d = '0;
        else                cnt_d = cnt_q + W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/trig_clk_div.sv
module trig_clk_div
    import tcd_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [WR_W-1:0]  wr_data,
    input  logic [NTRIG-1:0] trig_in,
    output logic             active,
    output logic             proc_ce,
    output logic             proc_lvl,
    output logic             bit_ce,
    output logic             bit_lvl,
    output logic [NPIN-1:0]  pin_clk,
    output logic [NPIN-1:0]  pin_oe
);
    typedef struct packed {
        cfg_t cfg;
        logic act;
    } state_t;

    state_t st_d, st_q;
    logic   trg_hit;

    tcd_trig_edge #(.NTRIG(NTRIG), .SEL_W(SEL_W)) u_edge (
        .clk     (clk),
        .rst_n   (rst_n),
        .trig_in (trig_in),
        .src     (st_q.cfg.src),
        .fall    (st_q.cfg.trig_fall),
        .hit     (trg_hit)
    );

    always_comb begin
        st_d.cfg = wr_en ? apply_write(st_q.cfg, wr_data, st_q.act) : st_q.cfg;
        st_d.act = st_d.cfg.run & (~st_d.cfg.trig_mode | st_q.act | trg_hit);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    tcd_div #(.W(PDIV_W)) u_proc (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (st_q.act),
        .keep     (st_d.act),
        .tick     (1'b1),
        .pass_lvl (st_q.act),
        .ratio_m1 (st_q.cfg.pdiv),
        .ce       (proc_ce),
        .lvl      (proc_lvl)
    );

    tcd_div #(.W(BDIV_W)) u_bit (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (st_q.act),
        .keep     (st_d.act),
        .tick     (proc_ce),
        .pass_lvl (proc_lvl),
        .ratio_m1 (st_q.cfg.bdiv),
        .ce       (bit_ce),
        .lvl      (bit_lvl)
    );

    for (genvar i = 0; i < NPIN; i++) begin : g_pin
        assign pin_clk[i] = st_q.cfg.pin_en[i] & bit_lvl;
        assign pin_oe[i]  = st_q.cfg.pin_dir[i];
    end

    assign active = st_q.act;
endmodule

// File: rtl/tcd_chk.sv
module tcd_chk
    import tcd_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              stop_wr,
    input logic              active,
    input logic              proc_ce,
    input logic              bit_ce,
    input logic [NPIN-1:0]   pin_clk,
    input logic [PDIV_W-1:0] pdiv
);
    a_r8_stop_clears: assert property (@(posedge clk) disable iff (!rst_n)
        stop_wr |=> !active);

    a_r4_ce_needs_active: assert property (@(posedge clk) disable iff (!rst_n)
        proc_ce |-> active);

    a_r5_bit_inside_proc: assert property (@(posedge clk) disable iff (!rst_n)
        bit_ce |-> proc_ce);

    a_r6_pins_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !active |-> (pin_clk == '0));

    a_r7_ratio_locked: assert property (@(posedge clk) disable iff (!rst_n)
        (active && $past(active)) |-> $stable(pdiv));

    a_r4_ce_spacing: assert property (@(posedge clk) disable iff (!rst_n)
        (proc_ce && pdiv != '0) |=> !proc_ce);
endmodule

bind trig_clk_div tcd_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .stop_wr (wr_en && !wr_data[0]),
    .active  (active),
    .proc_ce (proc_ce),
    .bit_ce  (bit_ce),
    .pin_clk (pin_clk),
    .pdiv    (st_q.cfg.pdiv)
);

// File: tb/trig_clk_div_tb.sv
module trig_clk_div_tb;
    import tcd_pkg::*;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             wr_en = 1'b0;
    logic [WR_W-1:0]  wr_data = '0;
    logic [NTRIG-1:0] trig_in = '0;
    logic             active, proc_ce, proc_lvl, bit_ce, bit_lvl;
    logic [NPIN-1:0]  pin_clk, pin_oe;

    always #5 clk = ~clk;

    trig_clk_div u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .trig_in(trig_in),
        .active(active), .proc_ce(proc_ce), .proc_lvl(proc_lvl), .bit_ce(bit_ce),
        .bit_lvl(bit_lvl), .pin_clk(pin_clk), .pin_oe(pin_oe)
    );

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    task automatic chk(string req, string what, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: got %0d expected %0d at %0t", req, what, act, exp, $time);
        end
    endtask

    // Reference model (R9 layout used for decoding)
    int m_run, m_pen, m_dir, m_mode, m_fall, m_sel, m_bdiv, m_pdiv;
    int m_act, m_pc, m_bc, m_s1, m_s2, m_s3;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_run = 0; m_pen = 0; m_dir = 0; m_mode = 0; m_fall = 0; m_sel = 0;
            m_bdiv = 0; m_pdiv = 0; m_act = 0; m_pc = 0; m_bc = 0;
            m_s1 = 0; m_s2 = 0; m_s3 = 0;
        end else begin
            int e, nact, old_sel;
            e = m_fall ? (m_s3 == 1 && m_s2 == 0) : (m_s2 == 1 && m_s3 == 0);
            old_sel = m_sel;
            if (wr_en) begin
                m_run = wr_data[0];
                m_pen = wr_data[2:1];
                m_dir = wr_data[5:4];
                if (m_act == 0) begin
                    m_mode = wr_data[3];
                    m_fall = wr_data[6];
                    m_sel  = wr_data[8:7];
                    m_bdiv = wr_data[12:9];
                    m_pdiv = wr_data[16:13];
                end
            end
            nact = (m_run != 0) && (m_mode == 0 || m_act != 0 || e != 0);
            if (m_act != 0 && nact != 0) begin
                if (m_pc == m_pdiv) begin
                    m_pc = 0;
                    m_bc = (m_bc == m_bdiv) ? 0 : m_bc + 1;
                end else m_pc = m_pc + 1;
            end else begin
                m_pc = 0; m_bc = 0;
            end
            m_act = nact;
            m_s3 = m_s2; m_s2 = m_s1; m_s1 = trig_in[old_sel];
        end
    end

    function automatic int exp_pce();
        return (m_act != 0 && m_pc == m_pdiv);
    endfunction
    function automatic int exp_plvl();
        return (m_act != 0) && (m_pdiv == 0 || m_pc >= (m_pdiv + 2) / 2);
    endfunction
    function automatic int exp_bce();
        return exp_pce() != 0 && m_bc == m_bdiv;
    endfunction
    function automatic int exp_blvl();
        if (m_act == 0) return 0;
        if (m_bdiv == 0) return exp_plvl();
        return m_bc >= (m_bdiv + 2) / 2;
    endfunction

    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk("R2", "active", active, m_act);
            chk("R4", "proc_ce", proc_ce, exp_pce());
            chk("R4", "proc_lvl", proc_lvl, exp_plvl());
            chk("R5", "bit_ce", bit_ce, exp_bce());
            chk("R5", "bit_lvl", bit_lvl, exp_blvl());
            for (int i = 0; i < NPIN; i++) begin
                chk("R6", "pin_clk", pin_clk[i], ((m_pen >> i) & 1) & exp_blvl());
                chk("R6", "pin_oe", pin_oe[i], (m_dir >> i) & 1);
            end
        end
    end

    function automatic logic [WR_W-1:0] mk(int run, int pen, int mode, int dir, int fall,
                                           int sel, int bdiv, int pdiv);
        logic [WR_W-1:0] w;
        w = '0;
        w[0] = run[0]; w[2:1] = pen[1:0]; w[3] = mode[0]; w[5:4] = dir[1:0];
        w[6] = fall[0]; w[8:7] = sel[1:0]; w[12:9] = bdiv[3:0]; w[16:13] = pdiv[3:0];
        return w;
    endfunction

    task automatic wr(logic [WR_W-1:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        #2_000_000;
        n_fail++;
        $display("FAIL watchdog: got hung expected finish");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        int c_ce, c_lvl, c_p0;
        repeat (3) @(negedge clk);
        chk("R1", "active in reset", active, 0);
        chk("R1", "outputs in reset", {proc_ce, proc_lvl, bit_ce, bit_lvl, pin_clk, pin_oe}, 0);
        rst_n = 1'b1;
        idle(2);
        chk("R1", "active after reset", active, 0);

        // R2: free mode, P=2 (odd ratio 3), B=1
        wr(mk(0, 3, 0, 1, 0, 0, 1, 2));
        wr(mk(1, 3, 0, 1, 0, 0, 1, 2));
        chk("R2", "active at write edge", active, 1);
        idle(40);

        // R7: ratio change ignored, pin 0 enable still taken
        wr(mk(1, 2, 0, 3, 0, 0, 1, 5));
        c_ce = 0; c_lvl = 0; c_p0 = 0;
        repeat (30) begin
            @(negedge clk);
            c_ce += proc_ce; c_lvl += proc_lvl; c_p0 += pin_clk[0];
        end
        chk("R7", "proc_ce count with locked ratio 3", c_ce, 10);
        chk("R4", "odd ratio high cycles", c_lvl, 10);
        chk("R7", "pin 0 disabled while active", c_p0, 0);
        chk("R7", "direction updated while active", pin_oe, 3);

        // R8: stop
        wr(mk(0, 3, 0, 1, 0, 0, 1, 2));
        chk("R8", "active after stop", active, 0);
        chk("R8", "proc_lvl after stop", proc_lvl, 0);

        // R4/R5 pass-through
        wr(mk(0, 3, 0, 1, 0, 0, 0, 0));
        wr(mk(1, 3, 0, 1, 0, 0, 0, 0));
        c_ce = 0; c_lvl = 0;
        repeat (20) begin
            c_ce += bit_ce; c_lvl += proc_lvl;
            @(negedge clk);
        end
        chk("R4", "pass-through level high", c_lvl, 20);
        chk("R5", "pass-through bit pulses", c_ce, 20);
        wr(mk(0, 3, 0, 1, 0, 0, 0, 0));

        // R5: P=1, B=15 -> bit period 32
        wr(mk(0, 3, 0, 1, 0, 0, 15, 1));
        wr(mk(1, 3, 0, 1, 0, 0, 15, 1));
        c_ce = 0; c_lvl = 0;
        repeat (320) begin
            c_ce += bit_ce; c_lvl += bit_lvl;
            @(negedge clk);
        end
        chk("R5", "divide by 16 bit pulses", c_ce, 10);
        chk("R5", "divide by 16 high cycles", c_lvl, 160);
        wr(mk(0, 3, 0, 1, 0, 0, 15, 1));

        // R3: trigger mode, rising, source 2
        trig_in = '0;
        wr(mk(0, 1, 1, 1, 0, 2, 1, 1));
        wr(mk(1, 1, 1, 1, 0, 2, 1, 1));
        idle(5);
        chk("R3", "no start without trigger", active, 0);
        trig_in[1] = 1'b1;
        idle(5);
        chk("R3", "other input ignored", active, 0);
        trig_in[2] = 1'b1;
        idle(2);
        chk("R3", "not yet active after two edges", active, 0);
        idle(1);
        chk("R3", "active after third edge", active, 1);
        idle(10);

        // R8: re-enable needs a new edge
        wr(mk(0, 1, 1, 1, 0, 2, 1, 1));
        wr(mk(1, 1, 1, 1, 0, 2, 1, 1));
        idle(8);
        chk("R8", "held trigger level does not restart", active, 0);

        // R3: falling sensitivity
        wr(mk(0, 1, 1, 1, 1, 2, 1, 1));
        wr(mk(1, 1, 1, 1, 1, 2, 1, 1));
        idle(4);
        chk("R3", "falling mode idle before edge", active, 0);
        trig_in[2] = 1'b0;
        idle(3);
        chk("R3", "falling edge starts", active, 1);
        idle(20);
        wr(mk(0, 1, 1, 1, 1, 2, 1, 1));

        // Mixed stimulus, compared against the model each cycle
        for (int k = 0; k < 400; k++) begin
            @(negedge clk);
            trig_in = NTRIG'($urandom);
            if (($urandom % 6) == 0) begin
                logic [WR_W-1:0] w;
                w = WR_W'($urandom);
                w[16:13] = 4'($urandom % 4);
                if (($urandom % 4) != 0) w[0] = 1'b1;
                wr_en = 1'b1; wr_data = w;
                @(negedge clk);
                wr_en = 1'b0;
            end
            idle($urandom % 8);
        end

        idle(2);
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule